// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block gathers interrupt requests from a set of peripheral lines into a request register. It picks one winner and offers that winner's index to a CPU. Each source has an enable bit and a 2-bit priority level field. Three levels exist, and a higher level always beats a lower one. Inside a level, the lower source index wins. A parameter names a group of system sources that always count as the top level, whatever their level field holds.

Each source is built as one of two types, chosen by a parameter. A pulse source raises its line for one clock. Its request bit latches the pulse and holds until the CPU accepts that source or software writes 0 to the bit. A level source holds its line until the peripheral clears it. CPU acceptance does not clear its bit. A software write of 0 clears the bit for one cycle only, and the bit sets again while the line is still high. The bit stays set after the line drops, until software writes 0.

The CPU side is a valid/ready pair that carries the vector index. `irq_valid_o` is high whenever an enabled request is pending. A transfer happens on a clock edge where both `irq_valid_o` and `irq_ready_i` are high. That transfer is the acknowledge, and it applies the per-type rule to the source named by `irq_vec_o`. Back-pressure is allowed, with one rule that differs from a plain stream: while `irq_ready_i` is low, the offered index follows the current winner. A newly arrived higher-priority request therefore replaces it. Nothing is cleared unless a transfer happens.

Top module: `irq_ctrl`

## Requirements
- R1: While reset is held, and at the first edge after it, all request bits, enable bits and level fields are 0, and `irq_valid_o` is low.
- R2: A one-cycle high on a pulse source's line sets its request bit at that edge, and the bit stays set with no further pulses.
- R3: A transfer (`irq_valid_o` and `irq_ready_i` both high at an edge) clears the request bit of the pulse source named by `irq_vec_o`, unless that source pulses in the same cycle.
- R4: A write with `cfg_sel_i` = 0 (request register) clears every request bit whose `cfg_data_i` bit is 0. Data bits of 1 leave their request bits unchanged.
- R5: When a pulse source pulses in the same cycle that a request-register write carries 0 for its bit, the bit stays set.
- R6: A transfer that names a level source leaves its request bit set.
- R7: A request-register write of 0 to a level source's bit clears it for exactly one cycle, and it sets again the next cycle while the line is high. After the line drops, the bit stays set until such a write clears it for good.
- R8: A write with `cfg_sel_i` = 1 loads the enable bits from `cfg_data_i[N_SRC-1:0]`. Only sources with both the enable bit and the request bit set compete, and `irq_valid_o` is high exactly when at least one does.
- R9: A write with `cfg_sel_i` = 2 loads the level fields, with source i at `cfg_data_i[2i+1:2i]`. Codes 3, 2 and 1 are levels 3, 2 and 1, and code 0 acts as level 1. Any competing request at a higher level wins over all lower-level ones.
- R10: Among competing requests at the same level, the lowest source index is offered on `irq_vec_o`.
- R11: Sources marked in `SYS_MASK` compete at level 3 regardless of their level field.
- R12: While `irq_ready_i` is low, or when `irq_valid_o` is low, no request bit is cleared by the CPU side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | N_SRC | Request line per source |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Write target: 0 request, 1 enable, 2 level, 3 none |
| cfg_data_i | input | 2*N_SRC | Write data |
| irq_valid_o | output | 1 | An enabled request is pending |
| irq_ready_i | input | 1 | CPU accepts the offered index |
| irq_vec_o | output | IDX_W | Index of the winning source |
| pend_o | output | N_SRC | Request register contents |

## Verification
Every result is due one clock after its stimulus. Request bits, enables and levels are registers, and `irq_valid_o` and `irq_vec_o` follow from those registers with no path from the inputs. A line pulse, a write or a transfer applied before edge k is therefore seen after edge k. The one case that spans two cycles is the level-source write of 0, which shows 0 after edge k and 1 again after edge k+1. The bench stamps each expected item with the cycle number it is due in and compares it at the falling edge of that cycle. Checks of the two-cycle case use two separate stamped items.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  // Targets of the register write port
  typedef enum logic [1:0] {
    SEL_REQ  = 2'd0,
    SEL_EN   = 2'd1,
    SEL_LVL  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  localparam int LVL_W  = 2;
  localparam int N_LVL  = 3;

  typedef logic [LVL_W-1:0] lvl_code_t;

  // Map a programmed code to a level number 1..3; code 0 acts as level 1
  function automatic lvl_code_t eff_level(input lvl_code_t code, input logic sys);
    lvl_code_t r;
    if (sys)                r = lvl_code_t'(N_LVL);
    else if (code == '0)    r = lvl_code_t'(1);
    else                    r = code;
    return r;
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int DW   = LVL_W * N_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [DW-1:0]    cfg_data_i,
  output logic [N_SRC-1:0] en_o,
  output logic [DW-1:0]    lvl_o
);

  logic [N_SRC-1:0] en_q;
  logic [DW-1:0]    lvl_q;
  logic             wr_en_sel;
  logic             wr_lvl_sel;

  always_comb begin
    wr_en_sel  = cfg_wr_i && (cfg_sel_i == SEL_EN);
    wr_lvl_sel = cfg_wr_i && (cfg_sel_i == SEL_LVL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (wr_en_sel)  en_q  <= cfg_data_i[N_SRC-1:0];
      if (wr_lvl_sel) lvl_q <= cfg_data_i;
    end
  end

  assign en_o  = en_q;
  assign lvl_o = lvl_q;

endmodule

// File: rtl/irq_pend_bits.sv
module irq_pend_bits #(
  parameter int               N_SRC      = 8,
  parameter logic [N_SRC-1:0] PULSE_MASK = '0,
  parameter int               IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wclr_en_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic             ack_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  output logic [N_SRC-1:0] pend_o
);

  logic [N_SRC-1:0] ack_hit;
  logic [N_SRC-1:0] wr_zero;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      ack_hit[i] = ack_i && (ack_idx_i == IDX_W'(i));
      wr_zero[i] = wclr_en_i && !wdata_i[i];
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic bit_q;
    if (PULSE_MASK[g]) begin : g_pulse
      // New pulse has precedence over any clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= src_i[g] | (bit_q & ~(wr_zero[g] | ack_hit[g]));
      end
    end else begin : g_level
      // Write-zero wins for one edge; acknowledge never clears
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          bit_q <= 1'b0;
        else if (wr_zero[g]) bit_q <= 1'b0;
        else                 bit_q <= bit_q | src_i[g];
      end
    end
    assign pend_o[g] = bit_q;
  end

endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic [N_SRC-1:0] vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_ctrl_pkg::*;
#(
  parameter int               N_SRC    = 8,
  parameter logic [N_SRC-1:0] SYS_MASK = '0,
  parameter int               IDX_W    = 3,
  localparam int              DW       = LVL_W * N_SRC
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [DW-1:0]    lvl_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [N_SRC-1:0]                 live;
  logic [N_LVL-1:0][N_SRC-1:0]      lvl_mask;
  logic [N_LVL-1:0]                 lvl_any;
  logic [N_LVL-1:0][IDX_W-1:0]      lvl_idx;

  always_comb begin
    live = pend_i & en_i;
    for (int i = 0; i < N_SRC; i++) begin
      for (int l = 0; l < N_LVL; l++) begin
        lvl_mask[l][i] = live[i] &&
          (eff_level(lvl_i[LVL_W*i +: LVL_W], SYS_MASK[i]) == lvl_code_t'(l + 1));
      end
    end
  end

  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    irq_first_set #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
      .vec_i (lvl_mask[l]),
      .any_o (lvl_any[l]),
      .idx_o (lvl_idx[l])
    );
  end

  // Ascending scan: the highest occupied level is assigned last
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int l = 0; l < N_LVL; l++) begin
      if (lvl_any[l]) begin
        valid_o = 1'b1;
        idx_o   = lvl_idx[l];
      end
    end
  end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int               N_SRC      = 8,
  parameter logic [N_SRC-1:0] PULSE_MASK = 8'h55,
  parameter logic [N_SRC-1:0] SYS_MASK   = 8'h80,
  localparam int              IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int              DW         = LVL_W * N_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req_i,
  input  logic             cfg_wr_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [DW-1:0]    cfg_data_i,
  output logic             irq_valid_o,
  input  logic             irq_ready_i,
  output logic [IDX_W-1:0] irq_vec_o,
  output logic [N_SRC-1:0] pend_o
);

  logic [N_SRC-1:0] en_w;
  logic [DW-1:0]    lvl_w;
  logic [N_SRC-1:0] pend_w;
  logic             valid_w;
  logic [IDX_W-1:0] idx_w;
  logic             xfer;
  logic             req_wr;

  assign xfer   = valid_w && irq_ready_i;
  assign req_wr = cfg_wr_i && (cfg_sel_i == SEL_REQ);

  irq_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_sel_i  (cfg_sel_i),
    .cfg_data_i (cfg_data_i),
    .en_o       (en_w),
    .lvl_o      (lvl_w)
  );

  irq_pend_bits #(
    .N_SRC      (N_SRC),
    .PULSE_MASK (PULSE_MASK),
    .IDX_W      (IDX_W)
  ) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_req_i),
    .wclr_en_i (req_wr),
    .wdata_i   (cfg_data_i[N_SRC-1:0]),
    .ack_i     (xfer),
    .ack_idx_i (idx_w),
    .pend_o    (pend_w)
  );

  irq_arb #(
    .N_SRC    (N_SRC),
    .SYS_MASK (SYS_MASK),
    .IDX_W    (IDX_W)
  ) u_arb (
    .pend_i  (pend_w),
    .en_i    (en_w),
    .lvl_i   (lvl_w),
    .valid_o (valid_w),
    .idx_o   (idx_w)
  );

  assign irq_valid_o = valid_w;
  assign irq_vec_o   = idx_w;
  assign pend_o      = pend_w;

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int               N_SRC      = 8,
  parameter logic [N_SRC-1:0] PULSE_MASK = '0,
  parameter int               IDX_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src,
  input logic             cfg_wr,
  input logic [1:0]       cfg_sel,
  input logic [N_SRC-1:0] cfg_lo,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic [IDX_W-1:0] irq_vec,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] en
);

  logic req_wr;
  assign req_wr = cfg_wr && (cfg_sel == 2'd0);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (pend == '0));

  // R8
  valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid == (|(pend & en)));

  // R10
  vec_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (pend[irq_vec] && en[irq_vec]));

  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    if (PULSE_MASK[g]) begin : g_pulse
      // R2
      pulse_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src[g] |=> pend[g]);
      // R3
      pulse_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ready && irq_vec == IDX_W'(g) && !src[g]) |=> !pend[g]);
    end else begin : g_level
      // R6
      level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[g] && !(req_wr && !cfg_lo[g])) |=> pend[g]);
      // R7
      level_wclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !cfg_lo[g]) |=> !pend[g]);
    end
  end

endmodule

bind irq_ctrl irq_ctrl_chk #(
  .N_SRC      (N_SRC),
  .PULSE_MASK (PULSE_MASK),
  .IDX_W      (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src       (src_req_i),
  .cfg_wr    (cfg_wr_i),
  .cfg_sel   (cfg_sel_i),
  .cfg_lo    (cfg_data_i[N_SRC-1:0]),
  .irq_valid (irq_valid_o),
  .irq_ready (irq_ready_i),
  .irq_vec   (irq_vec_o),
  .pend      (pend_o),
  .en        (en_w)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src = '0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [2:0]  irq_vec;
  logic [7:0]  pend;

  always #10 clk = ~clk;

  irq_ctrl #(.N_SRC(8), .PULSE_MASK(8'h55), .SYS_MASK(8'h80)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_req_i   (src),
    .cfg_wr_i    (cfg_wr),
    .cfg_sel_i   (cfg_sel),
    .cfg_data_i  (cfg_data),
    .irq_valid_o (irq_valid),
    .irq_ready_i (irq_ready),
    .irq_vec_o   (irq_vec),
    .pend_o      (pend)
  );

  typedef struct {
    int         due;
    string      tag;
    logic       v;
    logic [2:0] vec;
    logic [7:0] pnd;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every item whose due cycle has arrived
  always @(negedge clk) begin
    exp_t e;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      e = sb.pop_front();
      n_chk++;
      if (irq_valid !== e.v || pend !== e.pnd || (e.v && irq_vec !== e.vec)) begin
        n_bad++;
        $display("FAIL %s: valid/vec/pend got %0b/%0d/%h expected %0b/%0d/%h",
                 e.tag, irq_valid, irq_vec, pend, e.v, e.vec, e.pnd);
      end
    end
  end

  // Driver: apply one cycle of stimulus and queue the result due after the edge
  task automatic step(input string tag, input logic [7:0] s, input logic w,
                      input logic [1:0] sel, input logic [15:0] d, input logic rdy,
                      input logic ev, input logic [2:0] evec, input logic [7:0] ep);
    exp_t e;
    src = s; cfg_wr = w; cfg_sel = sel; cfg_data = d; irq_ready = rdy;
    e.due = cyc + 1; e.tag = tag; e.v = ev; e.vec = evec; e.pnd = ep;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // sel: 0 request, 1 enable, 2 level
    step("R1 reset state",           8'h00, 0, 0, 16'h0000, 0, 0, 0, 8'h00);
    step("R8 enable all, none pend", 8'h00, 1, 1, 16'h00FF, 0, 0, 0, 8'h00);
    step("R9 load levels",           8'h00, 1, 2, 16'h67A5, 0, 0, 0, 8'h00);
    step("R2 pulse src0 latches",    8'h01, 0, 0, 16'h0000, 0, 1, 0, 8'h01);
    step("R2 pulse bit holds",       8'h00, 0, 0, 16'h0000, 0, 1, 0, 8'h01);
    step("R9 level2 beats level1",   8'h04, 0, 0, 16'h0000, 0, 1, 2, 8'h05);
    step("R3 ack clears pulse",      8'h00, 0, 0, 16'h0000, 1, 1, 0, 8'h01);
    step("R7 level src3 sets",       8'h08, 0, 0, 16'h0000, 0, 1, 3, 8'h09);
    step("R6 ack keeps level bit",   8'h08, 0, 0, 16'h0000, 1, 1, 3, 8'h09);
    step("R7 write0 clears once",    8'h08, 1, 0, 16'h00F7, 0, 1, 0, 8'h01);
    step("R7 bit sets again",        8'h08, 0, 0, 16'h0000, 0, 1, 3, 8'h09);
    step("R7 held after line drop",  8'h00, 0, 0, 16'h0000, 0, 1, 3, 8'h09);
    step("R7 write0 after drop",     8'h00, 1, 0, 16'h00F7, 0, 1, 0, 8'h01);
    step("R7 stays removed",         8'h00, 0, 0, 16'h0000, 0, 1, 0, 8'h01);
    step("R2 pulse src6",            8'h40, 0, 0, 16'h0000, 0, 1, 6, 8'h41);
    step("R4 write clears only 0s",  8'h00, 1, 0, 16'h00FE, 0, 1, 6, 8'h40);
    step("R5 pulse beats write0",    8'h40, 1, 0, 16'h00BF, 0, 1, 6, 8'h40);
    step("R10 lower index in level", 8'h04, 0, 0, 16'h0000, 0, 1, 2, 8'h44);
    step("R9 level3 wins",           8'h10, 0, 0, 16'h0000, 0, 1, 4, 8'h54);
    step("R3 ack clears src4",       8'h00, 0, 0, 16'h0000, 1, 1, 2, 8'h44);
    step("R11 sys src forced lvl3",  8'h80, 0, 0, 16'h0000, 0, 1, 7, 8'hC4);
    step("R11 sys src removed",      8'h00, 1, 0, 16'h007F, 0, 1, 2, 8'h44);
    step("R12 no clear w/o ready",   8'h00, 0, 0, 16'h0000, 0, 1, 2, 8'h44);
    step("R8 disable src2",          8'h00, 1, 1, 16'h00FB, 0, 1, 6, 8'h44);
    step("R8 disable all",           8'h00, 1, 1, 16'h0000, 0, 0, 0, 8'h44);
    step("R12 ready w/o valid",      8'h00, 0, 0, 16'h0000, 1, 0, 0, 8'h44);
    step("R8 enable all again",      8'h00, 1, 1, 16'h00FF, 0, 1, 2, 8'h44);
    step("R9 code0 acts as lvl1",    8'h00, 1, 2, 16'h2000, 0, 1, 6, 8'h44);
    step("R3 ack clears src6",       8'h00, 0, 0, 16'h0000, 1, 1, 2, 8'h04);
    step("R4 write all zero",        8'h00, 1, 0, 16'h0000, 0, 0, 0, 8'h00);
    step("R4 idle after clear",      8'h00, 0, 0, 16'h0000, 0, 0, 0, 8'h00);
    @(negedge clk);
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run incomplete, got %0d checks expected completion", n_chk);
      report();
      $finish;
    end
  end

endmodule